// File: doc/BRIEF.md
# Watchdog Timer with Single and Paired Software Clear

This block guards a small microcontroller against runaway software. A counter advances on one of two tick sources, fixed by a static option: a free-running watchdog oscillator tick, or the instruction clock, which is the system clock divided by four. If software does not clear the counter in time, the counter wraps after 2^DIV_LOG2 ticks. The DIV_LOG2 parameter is 15 or 16 in a product and 15 by default.

A wrap while the core runs normally requests a full chip reset and sets a sticky timeout status bit. A wrap while the core sits in its halt low-power state requests a lighter warm reset, which the core uses to zero only its program counter and stack pointer. The counter is cleared by the active-low external reset, by the halt-entry strobe, or by software. Software clears in one of two ways, chosen by a static option. In single mode, one clear strobe is enough. In paired mode, two distinct strobes must both arrive, in either order, before the counter clears.

The block only produces tick enables internally and reset request pulses at its outputs. The oscillators and the state that gets reset belong to the core around it.

Top module: `wdt_supervisor`

## Requirements
- R1: With `opt_src_osc`=1, each cycle with `osc_tick`=1 advances the counter. After reset or a clear, the 2^DIV_LOG2-th tick causes a request pulse in the cycle that follows that tick's clock edge.
- R2: With `opt_src_osc`=0, the counter advances once every 4 clock cycles while `halt`=0. The first advance is on the 4th rising edge after reset is released.
- R3: A wrap with `halt`=0 drives `chip_rst_req` high for exactly one cycle, sets `to_flag`, and leaves `warm_rst_req` low.
- R4: A wrap with `halt`=1 drives `warm_rst_req` high for one cycle, keeps `chip_rst_req` low, and does not set `to_flag`.
- R5: With `opt_src_osc`=0 and `halt`=1, the counter does not advance.
- R6: A `halt_enter` strobe clears the counter.
- R7: With `opt_dual_clear`=0, a `clr_single` strobe clears the counter and `to_flag`. `clr_first` and `clr_second` have no effect in this mode.
- R8: With `opt_dual_clear`=1, the counter clears once both `clr_first` and `clr_second` have been seen since the last clear or reset. They may arrive in either order, in separate cycles or in the same cycle. Either strobe alone, or the same strobe repeated, has no effect, and `clr_single` is ignored in this mode.
- R9: A clear in the same cycle as the wrapping tick wins, and no reset is requested.
- R10: With `opt_enable`=0, no reset request is ever made and `to_flag` stays 0.
- R11: `rst_n`=0 clears the counter, `to_flag`, any half-completed paired clear and both request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low external reset, asynchronous |
| opt_enable | input | 1 | Static option: watchdog present |
| opt_src_osc | input | 1 | Static option: 1 selects oscillator tick, 0 selects instruction clock |
| opt_dual_clear | input | 1 | Static option: 1 selects paired clear mode |
| osc_tick | input | 1 | Watchdog oscillator tick, one clock wide, already synchronised |
| halt | input | 1 | Core is in the halt state |
| halt_enter | input | 1 | Strobe: halt instruction executed |
| clr_single | input | 1 | Strobe: single-mode clear |
| clr_first | input | 1 | Strobe: first paired clear |
| clr_second | input | 1 | Strobe: second paired clear |
| chip_rst_req | output | 1 | One-cycle full chip reset request |
| warm_rst_req | output | 1 | One-cycle warm reset request (program counter and stack pointer) |
| to_flag | output | 1 | Sticky timeout status |

## Verification
The bench targets the exact wrap cycle for both tick sources. A design that is off by one tick or one prescaler phase asserts its reset a cycle early or late. It walks a set of clear patterns in both software modes: a lone strobe, a repeated strobe, two strobes in either order, and two strobes in one cycle. A design that counts the same strobe twice, or forgets the first strobe, either lets the watchdog fire or suppresses it wrongly. It also clears in the very cycle of the wrapping tick, which catches a design that lets the tick win. It checks that a reset drops a half-finished pair, which catches a latch that survives reset. Finally it holds the core in halt with each source, which exposes a design that picks the wrong reset kind or keeps counting instruction ticks while the clock is stopped.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {SRC_INSTR = 1'b0, SRC_OSC = 1'b1} wdt_src_e;
  typedef enum logic {CLR_ONE = 1'b0, CLR_PAIR = 1'b1} wdt_clr_mode_e;

  // Paired clear completes when each half is either pending or arriving now.
  function automatic logic pair_done(input logic pend_a, input logic new_a,
                                     input logic pend_b, input logic new_b);
    return (pend_a | new_a) & (pend_b | new_b);
  endfunction
endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
  parameter int INST_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wdt_pkg::wdt_src_e src,
  input  logic          osc_tick,
  input  logic          halt,
  output logic          tick
);
  localparam int PW = (INST_DIV > 1) ? $clog2(INST_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(INST_DIV - 1);

  logic [PW-1:0] phase;
  logic          inst_tick;

  // The system clock stops in halt, so the prescaler freezes there.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase <= '0;
    else if (!halt)      phase <= (phase == PLAST) ? '0 : phase + PW'(1);
  end

  assign inst_tick = (phase == PLAST) && !halt;
  assign tick      = (src == wdt_pkg::SRC_OSC) ? osc_tick : inst_tick;
endmodule

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  wdt_pkg::wdt_clr_mode_e mode,
  input  logic clr_single,
  input  logic clr_first,
  input  logic clr_second,
  output logic sw_clear
);
  logic pend_first, pend_second;
  logic pair_hit;

  assign pair_hit = wdt_pkg::pair_done(pend_first, clr_first, pend_second, clr_second);
  assign sw_clear = enable && ((mode == wdt_pkg::CLR_PAIR) ? pair_hit : clr_single);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_first  <= 1'b0;
      pend_second <= 1'b0;
    end else if (!enable || mode != wdt_pkg::CLR_PAIR || sw_clear) begin
      pend_first  <= 1'b0;
      pend_second <= 1'b0;
    end else begin
      pend_first  <= pend_first  | clr_first;
      pend_second <= pend_second | clr_second;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int DIV_LOG2 = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  input  logic clear_cnt,
  input  logic clear_to,
  input  logic halt,
  output logic wrap,
  output logic chip_rst_req,
  output logic warm_rst_req,
  output logic to_flag
);
  localparam logic [DIV_LOG2-1:0] LAST = '1;
  localparam logic [DIV_LOG2-1:0] ONE  = DIV_LOG2'(1);

  logic [DIV_LOG2-1:0] cnt;

  function automatic logic [DIV_LOG2-1:0] bump(input logic [DIV_LOG2-1:0] c);
    return c + ONE;
  endfunction

  function automatic logic at_last(input logic [DIV_LOG2-1:0] c);
    return c == LAST;
  endfunction

  assign wrap = enable && tick && !clear_cnt && at_last(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!enable || clear_cnt) cnt <= '0;
    else if (tick)              cnt <= bump(cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_rst_req <= 1'b0;
      warm_rst_req <= 1'b0;
      to_flag      <= 1'b0;
    end else begin
      chip_rst_req <= wrap && !halt;
      warm_rst_req <= wrap && halt;
      if (wrap && !halt)  to_flag <= 1'b1;
      else if (clear_to)  to_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
  parameter int DIV_LOG2 = 15,
  parameter int INST_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic opt_enable,
  input  logic opt_src_osc,
  input  logic opt_dual_clear,
  input  logic osc_tick,
  input  logic halt,
  input  logic halt_enter,
  input  logic clr_single,
  input  logic clr_first,
  input  logic clr_second,
  output logic chip_rst_req,
  output logic warm_rst_req,
  output logic to_flag
);
  // Named internal events, visible to the bound checker.
  logic tick;
  logic sw_clear;
  logic clear_cnt;
  logic wrap;

  wdt_tick_sel #(.INST_DIV(INST_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n),
    .src(wdt_pkg::wdt_src_e'(opt_src_osc)),
    .osc_tick(osc_tick), .halt(halt), .tick(tick)
  );

  wdt_clear_ctl u_clr (
    .clk(clk), .rst_n(rst_n), .enable(opt_enable),
    .mode(wdt_pkg::wdt_clr_mode_e'(opt_dual_clear)),
    .clr_single(clr_single), .clr_first(clr_first), .clr_second(clr_second),
    .sw_clear(sw_clear)
  );

  assign clear_cnt = sw_clear || (opt_enable && halt_enter);

  wdt_counter #(.DIV_LOG2(DIV_LOG2)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(opt_enable), .tick(tick),
    .clear_cnt(clear_cnt), .clear_to(sw_clear), .halt(halt),
    .wrap(wrap), .chip_rst_req(chip_rst_req),
    .warm_rst_req(warm_rst_req), .to_flag(to_flag)
  );
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic opt_enable,
  input logic opt_src_osc,
  input logic opt_dual_clear,
  input logic halt,
  input logic clr_first,
  input logic clr_second,
  input logic tick,
  input logic sw_clear,
  input logic chip_rst_req,
  input logic warm_rst_req,
  input logic to_flag
);
  assert_chip_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst_req |=> !chip_rst_req);
  assert_chip_sets_to_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst_req |-> to_flag);
  assert_kinds_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip_rst_req && warm_rst_req));
  assert_warm_only_in_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_req |-> $past(halt));
  assert_warm_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_req |=> !warm_rst_req);
  assert_inst_frozen_in_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !opt_src_osc) |-> !tick);
  assert_pair_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_dual_clear && sw_clear) |-> (clr_first || clr_second));
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |=> (!chip_rst_req && !warm_rst_req));
  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_enable |=> (!chip_rst_req && !warm_rst_req));
endmodule

bind wdt_supervisor wdt_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .opt_enable(opt_enable), .opt_src_osc(opt_src_osc),
  .opt_dual_clear(opt_dual_clear), .halt(halt), .clr_first(clr_first),
  .clr_second(clr_second), .tick(tick), .sw_clear(sw_clear),
  .chip_rst_req(chip_rst_req), .warm_rst_req(warm_rst_req), .to_flag(to_flag)
);

// File: tb/sim_wdt_supervisor.sv
module sim_wdt_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int DIVL = 5;
  localparam int SPAN = 1 << DIVL;          // ticks per timeout = 32

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic opt_enable = 1'b1, opt_src_osc = 1'b1, opt_dual_clear = 1'b0;
  logic osc_tick = 1'b1, halt = 1'b0, halt_enter = 1'b0;
  logic clr_single = 1'b0, clr_first = 1'b0, clr_second = 1'b0;
  logic chip_rst_req, warm_rst_req, to_flag;

  int total = 0, bad = 0, pulses = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_supervisor #(.DIV_LOG2(DIVL)) u0 (
    .clk(clk), .rst_n(rst_n), .opt_enable(opt_enable), .opt_src_osc(opt_src_osc),
    .opt_dual_clear(opt_dual_clear), .osc_tick(osc_tick), .halt(halt),
    .halt_enter(halt_enter), .clr_single(clr_single), .clr_first(clr_first),
    .clr_second(clr_second), .chip_rst_req(chip_rst_req),
    .warm_rst_req(warm_rst_req), .to_flag(to_flag)
  );

  // Vector: {dual mode, strobe pattern[2:0], expect cleared}
  // patterns: 0 none, 1 single, 2 first only, 3 second only,
  //           4 first then second, 5 first twice, 6 both together, 7 second then first
  localparam int NV = 10;
  localparam logic [4:0] VEC [NV] = '{
    {1'b0, 3'd1, 1'b1}, {1'b0, 3'd4, 1'b0}, {1'b0, 3'd0, 1'b0},
    {1'b1, 3'd1, 1'b0}, {1'b1, 3'd2, 1'b0}, {1'b1, 3'd3, 1'b0},
    {1'b1, 3'd5, 1'b0}, {1'b1, 3'd4, 1'b1}, {1'b1, 3'd6, 1'b1},
    {1'b1, 3'd7, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: the posedge happens, then outputs are sampled at the negedge.
  task automatic cyc();
    @(negedge clk);
    if (chip_rst_req || warm_rst_req) pulses++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic do_reset();
    clr_single = 0; clr_first = 0; clr_second = 0; halt_enter = 0;
    rst_n = 0;
    run(2);
    rst_n = 1;
    pulses = 0;
  endtask

  task automatic strobe(input logic s, input logic a, input logic b);
    clr_single = s; clr_first = a; clr_second = b;
    cyc();
    clr_single = 0; clr_first = 0; clr_second = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R11: reset state
    check(!chip_rst_req && !warm_rst_req && !to_flag, "R11 reset outputs",
          {chip_rst_req, warm_rst_req, to_flag}, 0);

    // Table walk: R7, R8 clear patterns
    for (int v = 0; v < NV; v++) begin
      opt_dual_clear = VEC[v][4];
      opt_src_osc = 1; halt = 0;
      do_reset();
      run(SPAN - 4);
      case (VEC[v][3:1])
        3'd1: strobe(1, 0, 0);
        3'd2: strobe(0, 1, 0);
        3'd3: strobe(0, 0, 1);
        3'd4: begin strobe(0, 1, 0); strobe(0, 0, 1); end
        3'd5: begin strobe(0, 1, 0); strobe(0, 1, 0); end
        3'd6: strobe(0, 1, 1);
        3'd7: begin strobe(0, 0, 1); strobe(0, 1, 0); end
        default: ;
      endcase
      run(8);
      check(pulses == (VEC[v][0] ? 0 : 1),
            VEC[v][4] ? "R8 paired clear pattern" : "R7 single clear pattern",
            pulses, VEC[v][0] ? 0 : 1);
    end

    // R1 / R3: exact wrap cycle with oscillator source
    opt_dual_clear = 0; opt_src_osc = 1; halt = 0;
    do_reset();
    run(SPAN - 1);
    check(!chip_rst_req, "R1 no request before last tick", chip_rst_req, 0);
    run(1);
    check(chip_rst_req && !warm_rst_req, "R3 chip request on wrap", chip_rst_req, 1);
    check(to_flag, "R3 to_flag set", to_flag, 1);
    run(1);
    check(!chip_rst_req, "R3 request lasts one cycle", chip_rst_req, 0);
    check(to_flag, "R3 to_flag sticky", to_flag, 1);
    // R7: software clear drops to_flag
    strobe(1, 0, 0);
    check(!to_flag, "R7 clr_single clears to_flag", to_flag, 1'b0);
    // R11: external reset drops to_flag
    run(SPAN);
    check(to_flag, "R11 to_flag set again", to_flag, 1);
    do_reset();
    check(!to_flag, "R11 reset clears to_flag", to_flag, 0);

    // R2: instruction clock source, tick every 4th edge
    opt_src_osc = 0; osc_tick = 0;
    do_reset();
    run(4 * SPAN - 1);
    check(!chip_rst_req, "R2 no request one cycle early", chip_rst_req, 0);
    run(1);
    check(chip_rst_req, "R2 request on 4*span edge", chip_rst_req, 1);

    // R5: instruction clock frozen in halt
    halt = 1;
    do_reset();
    run(6 * SPAN);
    check(pulses == 0, "R5 no count in halt with instruction clock", pulses, 0);

    // R4: oscillator keeps counting in halt -> warm reset
    opt_src_osc = 1; osc_tick = 1; halt = 1;
    do_reset();
    run(SPAN);
    check(warm_rst_req && !chip_rst_req, "R4 warm request in halt",
          {chip_rst_req, warm_rst_req}, 1);
    check(!to_flag, "R4 to_flag untouched", to_flag, 0);
    run(1);
    check(!warm_rst_req, "R4 warm request one cycle", warm_rst_req, 0);

    // R6: halt entry clears counter
    halt = 0;
    do_reset();
    run(SPAN - 4);
    halt_enter = 1; cyc(); halt_enter = 0;
    run(10);
    check(pulses == 0, "R6 halt_enter clears count", pulses, 0);

    // R9: clear in the wrapping cycle wins
    do_reset();
    run(SPAN - 1);
    strobe(1, 0, 0);
    run(4);
    check(pulses == 0, "R9 clear beats wrap tick", pulses, 0);
    opt_dual_clear = 1;
    do_reset();
    run(SPAN - 3);
    strobe(0, 1, 0); run(1); strobe(0, 0, 1);
    run(4);
    check(pulses == 0, "R9 paired clear on wrap tick", pulses, 0);

    // R11: reset drops a half-finished pair
    do_reset();
    run(5);
    strobe(0, 1, 0);
    do_reset();
    run(SPAN - 4);
    strobe(0, 0, 1);
    run(8);
    check(pulses == 1, "R11 pending pair dropped by reset", pulses, 1);

    // R10: disabled watchdog
    opt_enable = 0; opt_dual_clear = 0;
    do_reset();
    run(4 * SPAN);
    check(pulses == 0 && !to_flag, "R10 disabled never requests", pulses, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule